// File: doc/BRIEF.md
# Register Rename Tag Table

This block tracks where each architectural floating-point register gets its value in an out-of-order core. Each register has one entry. An entry holds either a committed value or the tag of the in-flight instruction that will produce that value. A presence flag says which of the two the entry holds.

Decode uses the table in three steps. First it reads the two source registers, and each read returns a value or a pending tag. Then it binds a freshly allocated tag to the destination register. Functional units publish each result with its tag on a broadcast port. Every entry still waiting on that tag takes the value and becomes present again.

Source reads are combinational and return the register's contents as they stood before this cycle's rename. A broadcast that arrives in the same cycle is forwarded to the reads. Rename and capture take effect at the next clock edge.

Top module: `rt_rename_table`

## Requirements
- R1: After reset, every register reads back with present = 1 and payload = 0.
- R2: A rename (renValid = 1, renReg, renTag) takes effect from the next cycle. From then on, a read of renReg returns present = 0 and a payload equal to renTag, zero-extended into the low TAG_W bits.
- R3: A read of a register that holds a value returns present = 1 and that value as payload.
- R4: A valid broadcast (bcValid = 1, bcTag, bcData) updates every pending entry whose tag equals bcTag. From the next cycle each such entry reads present = 1 with payload bcData. This applies to several entries at once.
- R5: A broadcast with bcValid = 0, or with a tag that no pending entry holds, changes nothing. A present entry also ignores a broadcast when the low bits of its value happen to equal bcTag.
- R6: A rename and a matching broadcast may hit the same register in the same cycle. The rename wins, and the entry is left pending on the new tag.
- R7: In the same cycle as a valid broadcast, a read of a pending register whose tag equals bcTag returns present = 1 and payload = bcData.
- R8: A read of the register being renamed in the same cycle returns that register's prior contents, not the new tag.
- R9: A later rename of a register replaces its earlier pending tag. A broadcast of the replaced tag then leaves the entry pending.
- R10: With renValid = 0, the rename register and tag inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| srcAReg | input | 3 | First source register index |
| srcBReg | input | 3 | Second source register index |
| renValid | input | 1 | Destination rename strobe |
| renReg | input | 3 | Destination register index |
| renTag | input | 4 | Tag bound to the destination |
| bcValid | input | 1 | Result broadcast strobe |
| bcTag | input | 4 | Tag of the broadcast result |
| bcData | input | 16 | Broadcast result value |
| srcAPresent | output | 1 | First source holds a value (1) or a tag (0) |
| srcAPayload | output | 16 | First source value, or its tag zero-extended |
| srcBPresent | output | 1 | Second source holds a value (1) or a tag (0) |
| srcBPayload | output | 16 | Second source value, or its tag zero-extended |

## Verification
The assertions assume that all inputs are known while reset is released, and that reset is held across at least one clock edge before use. The stimulus drives every input to a defined idle value from time zero and keeps both strobes low during reset. The duplicate-tag step, in which two registers wait on one tag, is deliberate: it exercises the every-matching-entry rule. Outside that step, each pending tag is bound to exactly one register, as a real allocator would ensure.

// File: rtl/rt_pkg.sv
package rt_pkg;
  parameter int unsigned NUM_REGS = 8;
  parameter int unsigned TAG_W    = 4;
  parameter int unsigned DATA_W   = 16;
  localparam int unsigned REG_W   = $clog2(NUM_REGS);

  typedef logic [REG_W-1:0]  regIdx_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [DATA_W-1:0] data_t;

  // Strobes from control to datapath, one bit per register entry
  typedef struct packed {
    logic [NUM_REGS-1:0] renameEn;
    logic [NUM_REGS-1:0] captureEn;
    logic [NUM_REGS-1:0] forwardHit;
  } rtStrobe_t;
endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_pkg::*;
(
  input  logic                           renValid,
  input  regIdx_t                        renReg,
  input  logic                           bcValid,
  input  tag_t                           bcTag,
  input  logic [NUM_REGS-1:0]            entryPresent,
  input  logic [NUM_REGS-1:0][TAG_W-1:0] entryTag,
  output rtStrobe_t                      strobes
);
  logic [NUM_REGS-1:0] tagMatch;
  logic [NUM_REGS-1:0] renameDec;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    always_comb begin
      renameDec[i] = renValid && (renReg == regIdx_t'(i));
      tagMatch[i]  = bcValid && !entryPresent[i] && (entryTag[i] == bcTag);
    end
  end

  always_comb begin
    strobes.renameEn   = renameDec;
    strobes.forwardHit = tagMatch;
    // a younger producer overrides a capture into the same entry
    strobes.captureEn  = tagMatch & ~renameDec;
  end
endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  rtStrobe_t                      strobes,
  input  tag_t                           renTag,
  input  data_t                          bcData,
  input  regIdx_t                        srcAReg,
  input  regIdx_t                        srcBReg,
  output logic                           srcAPresent,
  output data_t                          srcAPayload,
  output logic                           srcBPresent,
  output data_t                          srcBPayload,
  output logic [NUM_REGS-1:0]            entryPresent,
  output logic [NUM_REGS-1:0][TAG_W-1:0] entryTag
);
  logic  [NUM_REGS-1:0] presentQ;
  data_t                payloadQ [NUM_REGS];

  // one field per entry: the value when present, else the tag in its low bits
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) begin
        presentQ[i] <= 1'b1;
        payloadQ[i] <= '0;
      end else if (strobes.renameEn[i]) begin
        presentQ[i] <= 1'b0;
        payloadQ[i] <= data_t'(renTag);
      end else if (strobes.captureEn[i]) begin
        presentQ[i] <= 1'b1;
        payloadQ[i] <= bcData;
      end
    end
  end

  always_comb begin
    entryPresent = presentQ;
    for (int i = 0; i < NUM_REGS; i++) entryTag[i] = payloadQ[i][TAG_W-1:0];
  end

  // reads see the pre-rename contents, with a live broadcast forwarded
  always_comb begin
    srcAPresent = presentQ[srcAReg] | strobes.forwardHit[srcAReg];
    srcAPayload = strobes.forwardHit[srcAReg] ? bcData : payloadQ[srcAReg];
    srcBPresent = presentQ[srcBReg] | strobes.forwardHit[srcBReg];
    srcBPayload = strobes.forwardHit[srcBReg] ? bcData : payloadQ[srcBReg];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    a_r2_rename_pending: assert property (@(posedge clk) disable iff (!rstN)
      strobes.renameEn[i] |=> !presentQ[i] && payloadQ[i] == data_t'($past(renTag)));
    a_r4_capture_sets: assert property (@(posedge clk) disable iff (!rstN)
      strobes.captureEn[i] |=> presentQ[i] && payloadQ[i] == $past(bcData));
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.renameEn[i] && !strobes.captureEn[i]
        |=> $stable(presentQ[i]) && $stable(payloadQ[i]));
  end

  a_r6_rename_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.renameEn & strobes.captureEn) == '0);
endmodule

// File: rtl/rt_rename_table.sv
module rt_rename_table
  import rt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  srcAReg,
  input  logic [REG_W-1:0]  srcBReg,
  input  logic              renValid,
  input  logic [REG_W-1:0]  renReg,
  input  logic [TAG_W-1:0]  renTag,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcData,
  output logic              srcAPresent,
  output logic [DATA_W-1:0] srcAPayload,
  output logic              srcBPresent,
  output logic [DATA_W-1:0] srcBPayload
);
  rtStrobe_t                      strobes;
  logic [NUM_REGS-1:0]            entryPresent;
  logic [NUM_REGS-1:0][TAG_W-1:0] entryTag;

  rt_ctrl ctrl_i (
    .renValid     (renValid),
    .renReg       (renReg),
    .bcValid      (bcValid),
    .bcTag        (bcTag),
    .entryPresent (entryPresent),
    .entryTag     (entryTag),
    .strobes      (strobes)
  );

  rt_datapath dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .renTag       (renTag),
    .bcData       (bcData),
    .srcAReg      (srcAReg),
    .srcBReg      (srcBReg),
    .srcAPresent  (srcAPresent),
    .srcAPayload  (srcAPayload),
    .srcBPresent  (srcBPresent),
    .srcBPayload  (srcBPayload),
    .entryPresent (entryPresent),
    .entryTag     (entryTag)
  );
endmodule

// File: tb/rt_rename_table_tb.sv
`timescale 1ns/100ps
module rt_rename_table_tb_top;
  import rt_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [REG_W-1:0] srcAReg = '0, srcBReg = '0, renReg = '0;
  logic renValid = 1'b0, bcValid = 1'b0;
  logic [TAG_W-1:0] renTag = '0, bcTag = '0;
  logic [DATA_W-1:0] bcData = '0;
  logic srcAPresent, srcBPresent;
  logic [DATA_W-1:0] srcAPayload, srcBPayload;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rt_rename_table dut_i (.*);

  typedef struct packed {
    logic       rv; logic [2:0] rr; logic [3:0] rt;
    logic       bv; logic [3:0] bt; logic [15:0] bd;
    logic [2:0] sa; logic [2:0] sb;
    logic       ap; logic [15:0] ad;
    logic       bp; logic [15:0] bdx;
    logic [7:0] req;
  } vec_t;

  // fields: rename v/reg/tag, broadcast v/tag/data, srcA, srcB,
  // expected A present/payload, expected B present/payload, requirement
  localparam vec_t VECS [19] = '{
    '{0,0,0, 0,0,16'h0000, 0,7, 1,16'h0000, 1,16'h0000, 3},   // R3 idle read
    '{1,1,3, 0,0,16'h0000, 1,2, 1,16'h0000, 1,16'h0000, 8},   // R8 read during rename
    '{1,2,5, 0,0,16'h0000, 1,2, 0,16'h0003, 1,16'h0000, 2},   // R2 pending tag
    '{0,0,0, 1,5,16'hBEEF, 2,1, 1,16'hBEEF, 0,16'h0003, 7},   // R7 forward
    '{0,0,0, 1,9,16'h1111, 2,1, 1,16'hBEEF, 0,16'h0003, 4},   // R4 captured, R5 no match
    '{1,1,6, 0,3,16'h0000, 1,4, 0,16'h0003, 1,16'h0000, 8},   // R8
    '{0,0,0, 1,3,16'h2222, 1,4, 0,16'h0006, 1,16'h0000, 9},   // R9 old tag ignored
    '{1,1,8, 1,6,16'h6666, 1,3, 1,16'h6666, 1,16'h0000, 7},   // R7 with same-cycle rename
    '{0,0,0, 0,0,16'h0000, 1,2, 0,16'h0008, 1,16'hBEEF, 6},   // R6 rename wins
    '{0,0,0, 0,8,16'h8888, 1,2, 0,16'h0008, 1,16'hBEEF, 5},   // R5 valid low
    '{0,0,0, 1,15,16'h1234, 2,1, 1,16'hBEEF, 0,16'h0008, 5},  // R5 present entry ignores
    '{0,0,0, 1,8,16'hABCD, 1,2, 1,16'hABCD, 1,16'hBEEF, 7},   // R7
    '{0,1,2, 0,0,16'h0000, 1,5, 1,16'hABCD, 1,16'h0000, 4},   // R4 captured, R10 rename low
    '{0,0,0, 0,0,16'h0000, 1,2, 1,16'hABCD, 1,16'hBEEF, 10},  // R10 no change
    '{1,5,10, 0,0,16'h0000, 5,6, 1,16'h0000, 1,16'h0000, 8},  // R8
    '{1,6,10, 0,0,16'h0000, 5,6, 0,16'h000A, 1,16'h0000, 2},  // R2
    '{0,0,0, 1,10,16'h5A5A, 5,6, 1,16'h5A5A, 1,16'h5A5A, 7},  // R7 both ports
    '{0,0,0, 0,0,16'h0000, 5,6, 1,16'h5A5A, 1,16'h5A5A, 4},   // R4 two entries captured
    '{0,0,0, 0,0,16'h0000, 0,3, 1,16'h0000, 1,16'h0000, 3}    // R3
  };

  task automatic checkOut(input string req, input logic gotP, input logic [15:0] gotD,
                          input logic expP, input logic [15:0] expD);
    checks++;
    if (gotP !== expP || gotD !== expD) begin
      fails++;
      $display("FAIL %s: got present=%0b payload=%h, expected present=%0b payload=%h",
               req, gotP, gotD, expP, expD);
    end
  endtask

  task automatic checkAllReset(input string req);
    for (int r = 0; r < NUM_REGS; r++) begin
      @(negedge clk);
      srcAReg = REG_W'(r);
      srcBReg = REG_W'(NUM_REGS - 1 - r);
      #1;
      checkOut(req, srcAPresent, srcAPayload, 1'b1, 16'h0000);
      checkOut(req, srcBPresent, srcBPayload, 1'b1, 16'h0000);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    checkAllReset("R1");

    for (int v = 0; v < 19; v++) begin
      @(negedge clk);
      renValid = VECS[v].rv; renReg = VECS[v].rr; renTag = VECS[v].rt;
      bcValid  = VECS[v].bv; bcTag  = VECS[v].bt; bcData = VECS[v].bd;
      srcAReg  = VECS[v].sa; srcBReg = VECS[v].sb;
      #1;
      checkOut($sformatf("R%0d vec%0d A", VECS[v].req, v), srcAPresent, srcAPayload,
               VECS[v].ap, VECS[v].ad);
      checkOut($sformatf("R%0d vec%0d B", VECS[v].req, v), srcBPresent, srcBPayload,
               VECS[v].bp, VECS[v].bdx);
    end

    // R6 directed: broadcast and rename on same pending entry
    @(negedge clk);
    renValid = 1; renReg = 3; renTag = 4'h2; bcValid = 0;
    @(negedge clk);
    renValid = 1; renReg = 3; renTag = 4'hC; bcValid = 1; bcTag = 4'h2; bcData = 16'h3333;
    @(negedge clk);
    renValid = 0; bcValid = 0; srcAReg = 3; #1;
    checkOut("R6 directed", srcAPresent, srcAPayload, 1'b0, 16'h000C);

    // R1: mid-run reset clears every entry
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    checkAllReset("R1 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule